// File: doc/BRIEF.md
# Disk Pack Controller Command and Status Registers

This block is the register front end of a controller for up to eight disk pack drives on an 18-bit processor I/O bus. The processor issues I/O instructions as a device select plus a 6-bit pulse word. The block decodes each one into a skip test, a register read, a register load, or a mix of these. It holds the disk address, memory address and word count registers, and two 18-bit status words called A and B. Status A carries the unit select, the function code, the interrupt enables, the go bit and the address-range and header errors. Status B carries the per-unit attention flags and the transfer error flags.

On every cycle the block mixes live status from the selected drive (write locked, attached, seeking, cylinder out of range) into both status words. From that result it forms the error summary bit and the single interrupt request. A small launch state machine runs the handoff to the transfer engine. A function load that leaves go set starts a command if the controller is free and the selected drive is not seeking. The machine moves from `LS_IDLE` to `LS_LAUNCH`, where it emits a one-cycle start strobe with unit and function. It then goes to `LS_RUN`, and returns to `LS_IDLE` once the engine's busy input falls. The engine reports results back by OR-ing flag bits into the status words through two post inputs.

Top module: `dpk_ctrl_regs`

## Requirements
- R1: After reset, status A, status B, disk address, memory address and word count read as zero, irq is low and go_strobe is low. The bench holds all drives attached, not seeking and in range.
- R2: iot_pulse bit 0 requests a skip test, bit 1 a read and bit 2 a load, and bits 5:4 give the subcode. With iot_dev=0, skip subcodes 0..3 test (done or error or any attention), any attention, done, and error. With iot_dev=1, subcode 1 always skips.
- R3: A read ORs the selected value into ac_in to form ac_out. Device 0 subcodes 0 and 1 read status A and status B. Device 1 subcodes 1, 2 and 3 read the disk address, memory address and word count. Device 1 subcode 0 reads zero.
- R4: Device 0 load subcodes 0, 2 and 3 load the disk address, memory address and word count from ac_in. A disk address load sets bad-sector (A bit 5) when sector bits 3:0 are 10 or more. It sets bad-surface (A bit 6) when surface bits 9:5 are 20 or more, and bad-cylinder (A bit 7) when cylinder bits 17:10 are 203 or more.
- R5: Device 1 load subcodes 0..3 update A bits 17:9 (unit 17:15, function 14:12, bit 11 done-interrupt enable, bit 10 attention-interrupt enable, bit 9 go). Subcode 0 clears them, 1 ANDs them with ac_in, 2 ORs ac_in into them, and 3 replaces them. Each mode also clears done (A bit 1).
- R6: A load issued while busy is high, or while a launch is still in progress, changes no register. Instead it sets the programming-error flag, B bit 8.
- R7: Device 0 load subcode 1 clears header-not-found (A bit 4) and done. It also clears B bits 8:2 and keeps B bit 9 and the attention flags.
- R8: A bit 0 is high exactly when any of A bits 8:4, A bit 2, or B bits 9:2 is high.
- R9: For the unit selected in A bits 17:15: write lock sets A bit 3. Not attached sets B bits 9 and 0. Attached and seeking sets B bits 1 and 0. Attached, not seeking and cylinder out of range sets A bit 2.
- R10: irq is high when (done or error) and A bit 11 are both set, or when any attention flag (B bit 17-u for unit u) and A bit 10 are both set. Otherwise irq is low.
- R11: A function load accepted with go set, naming a unit that is not seeking, gives go_strobe high for exactly the next cycle, with go_unit and go_func from the new A. The same load clears header-not-found, B bits 8:2 and that unit's attention flag. No strobe follows when the unit is seeking or the load was blocked.
- R12: post_a bits 8:4 and 1, and post_b bits 17:2, are ORed into the stored status on the clock edge of the cycle they are presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iot_valid | input | 1 | I/O instruction present this cycle |
| iot_dev | input | 1 | Device code select: 0 status/address group, 1 function group |
| iot_pulse | input | 6 | Pulse word: bits 5:4 subcode, bit 2 load, bit 1 read, bit 0 skip |
| ac_in | input | 18 | Accumulator value from the processor |
| ac_out | output | 18 | Accumulator value returned, with read data ORed in |
| skip | output | 1 | Skip condition met |
| unit_wlock | input | 8 | Per-unit write lock |
| unit_attached | input | 8 | Per-unit medium attached |
| unit_seeking | input | 8 | Per-unit seek or recalibrate in progress |
| unit_cyl_bad | input | 8 | Per-unit current cylinder out of range |
| busy | input | 1 | Transfer engine busy |
| post_a | input | 18 | Flags from the engine to OR into status A |
| post_b | input | 18 | Flags from the engine to OR into status B |
| go_strobe | output | 1 | One-cycle command start |
| go_unit | output | 3 | Unit of the started command |
| go_func | output | 3 | Function of the started command |
| irq | output | 1 | Interrupt request |

## Verification
The in-line properties check on every cycle that the launch strobe is a single pulse and never follows a busy cycle. They also check that a blocked load leaves the disk address untouched and raises the programming-error flag, that a function load drops done, and that clear-status drops the flags it owns. The skip and read decode, the exact bit layout of both status words and the range limits of the disk address fields can only be shown by the bench's scenarios. The same holds for the mixing of live drive status for different selected units, the interrupt conditions and the clearing of the attention flag on launch.

// File: rtl/dpk_pkg.sv
package dpk_pkg;
    parameter int WORD_W = 18;
    parameter int NUNITS = 8;
    parameter int UNIT_W = $clog2(NUNITS);
    parameter int FUNC_W = 3;

    // status A bit positions
    parameter int A_UNIT_MSB = WORD_W - 1;
    parameter int A_FUNC_MSB = A_UNIT_MSB - UNIT_W;
    parameter int A_IE_DONE  = 11;
    parameter int A_IE_ATTN  = 10;
    parameter int A_GO       = 9;
    parameter int A_SW_LSB   = 9;
    parameter int A_WLE      = 8;
    parameter int A_BADCYL   = 7;
    parameter int A_BADSURF  = 6;
    parameter int A_BADSECT  = 5;
    parameter int A_NOHDR    = 4;
    parameter int A_SELWL    = 3;
    parameter int A_SELSI    = 2;
    parameter int A_DONE     = 1;
    parameter int A_ERR      = 0;

    // status B bit positions
    parameter int B_ATT0     = WORD_W - 1;
    parameter int B_ATT_LSB  = B_ATT0 - NUNITS + 1;
    parameter int B_UNSAFE   = 9;
    parameter int B_PGM      = 8;
    parameter int B_XERR_LSB = 2;
    parameter int B_SEEKING  = 1;
    parameter int B_NOTRDY   = 0;

    // disk address fields
    parameter int DA_SECT_LSB = 0;
    parameter int DA_SECT_W   = 4;
    parameter int DA_SURF_LSB = 5;
    parameter int DA_SURF_W   = 5;
    parameter int DA_CYL_LSB  = 10;
    parameter int DA_CYL_W    = 8;

    typedef enum logic [2:0] {
        LD_NONE, LD_DADDR, LD_CLRST, LD_MADDR, LD_WCNT, LD_FUNC
    } load_e;

    typedef enum logic [1:0] {
        FM_CLEAR, FM_ANDZ, FM_ORONE, FM_FULL
    } fmode_e;

    typedef enum logic [2:0] {
        RD_NONE, RD_ZERO, RD_STA, RD_STB, RD_DADDR, RD_MADDR, RD_WCNT
    } rdsel_e;

    typedef enum logic [2:0] {
        SK_NONE, SK_ANY, SK_ATTN, SK_DONE, SK_ERR, SK_ALWAYS
    } skip_e;

    typedef enum logic [1:0] {
        LS_IDLE, LS_LAUNCH, LS_RUN
    } lstate_e;
endpackage

// File: rtl/dpk_iot_decode.sv
module dpk_iot_decode
    import dpk_pkg::*;
(
    input  logic       valid,
    input  logic       dev,
    input  logic [5:0] pulse,
    output load_e      ld,
    output fmode_e     fm,
    output rdsel_e     rd,
    output skip_e      sk
);
    logic [1:0] sub;
    assign sub = pulse[5:4];

    always_comb begin
        ld = LD_NONE;
        fm = FM_CLEAR;
        rd = RD_NONE;
        sk = SK_NONE;
        if (valid) begin
            if (!dev) begin
                if (pulse[0]) begin
                    unique case (sub)
                        2'd0: sk = SK_ANY;
                        2'd1: sk = SK_ATTN;
                        2'd2: sk = SK_DONE;
                        default: sk = SK_ERR;
                    endcase
                end
                if (pulse[1]) begin
                    unique case (sub)
                        2'd0: rd = RD_STA;
                        2'd1: rd = RD_STB;
                        default: rd = RD_NONE;
                    endcase
                end
                if (pulse[2]) begin
                    unique case (sub)
                        2'd0: ld = LD_DADDR;
                        2'd1: ld = LD_CLRST;
                        2'd2: ld = LD_MADDR;
                        default: ld = LD_WCNT;
                    endcase
                end
            end else begin
                if (pulse[0] && sub == 2'd1) sk = SK_ALWAYS;
                if (pulse[1]) begin
                    unique case (sub)
                        2'd0: rd = RD_ZERO;
                        2'd1: rd = RD_DADDR;
                        2'd2: rd = RD_MADDR;
                        default: rd = RD_WCNT;
                    endcase
                end
                if (pulse[2]) begin
                    ld = LD_FUNC;
                    unique case (sub)
                        2'd0: fm = FM_CLEAR;
                        2'd1: fm = FM_ANDZ;
                        2'd2: fm = FM_ORONE;
                        default: fm = FM_FULL;
                    endcase
                end
            end
        end
    end
endmodule

// File: rtl/dpk_unit_status.sv
module dpk_unit_status
    import dpk_pkg::*;
#(
    parameter int N  = NUNITS,
    parameter int UW = $clog2(N)
) (
    input  logic [UW-1:0] sel,
    input  logic [N-1:0]  wlock,
    input  logic [N-1:0]  attached,
    input  logic [N-1:0]  seeking,
    input  logic [N-1:0]  cyl_bad,
    output logic          sel_wlock,
    output logic          sel_seek_inc,
    output logic          sel_unsafe,
    output logic          sel_seeking,
    output logic          sel_not_ready
);
    always_comb begin
        sel_wlock     = wlock[sel];
        sel_seek_inc  = 1'b0;
        sel_unsafe    = 1'b0;
        sel_seeking   = 1'b0;
        sel_not_ready = 1'b0;
        if (!attached[sel]) begin
            sel_unsafe    = 1'b1;
            sel_not_ready = 1'b1;
        end else if (seeking[sel]) begin
            sel_seeking   = 1'b1;
            sel_not_ready = 1'b1;
        end else if (cyl_bad[sel]) begin
            sel_seek_inc  = 1'b1;
        end
    end
endmodule

// File: rtl/dpk_launch_fsm.sv
module dpk_launch_fsm
    import dpk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch_req,
    input  logic [UNIT_W-1:0] unit_in,
    input  logic [FUNC_W-1:0] func_in,
    input  logic              busy_in,
    output logic              go_strobe,
    output logic [UNIT_W-1:0] go_unit,
    output logic [FUNC_W-1:0] go_func,
    output logic              in_flight
);
    lstate_e state_q, state_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LS_IDLE;
            go_unit <= '0;
            go_func <= '0;
        end else begin
            state_q <= state_n;
            if (state_q == LS_IDLE && launch_req) begin
                go_unit <= unit_in;
                go_func <= func_in;
            end
        end
    end

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            LS_IDLE:   if (launch_req) state_n = LS_LAUNCH;
            LS_LAUNCH: state_n = LS_RUN;
            LS_RUN:    if (!busy_in) state_n = LS_IDLE;
            default:   state_n = LS_IDLE;
        endcase
    end

    always_comb begin
        go_strobe = (state_q == LS_LAUNCH);
        in_flight = (state_q != LS_IDLE);
    end

    p_strobe_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        go_strobe |=> !go_strobe);
    p_no_launch_after_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        busy_in |=> !go_strobe);
endmodule

// File: rtl/dpk_ctrl_regs.sv
module dpk_ctrl_regs
    import dpk_pkg::*;
#(
    parameter int NSECT = 10,
    parameter int NSURF = 20,
    parameter int NCYL  = 203
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              iot_valid,
    input  logic              iot_dev,
    input  logic [5:0]        iot_pulse,
    input  logic [WORD_W-1:0] ac_in,
    output logic [WORD_W-1:0] ac_out,
    output logic              skip,
    input  logic [NUNITS-1:0] unit_wlock,
    input  logic [NUNITS-1:0] unit_attached,
    input  logic [NUNITS-1:0] unit_seeking,
    input  logic [NUNITS-1:0] unit_cyl_bad,
    input  logic              busy,
    input  logic [WORD_W-1:0] post_a,
    input  logic [WORD_W-1:0] post_b,
    output logic              go_strobe,
    output logic [UNIT_W-1:0] go_unit,
    output logic [FUNC_W-1:0] go_func,
    output logic              irq
);
    localparam logic [WORD_W-1:0] POST_A_MASK = 18'o000762;
    localparam logic [WORD_W-1:0] POST_B_MASK = 18'o777774;
    localparam int SW_W = WORD_W - A_SW_LSB;

    load_e  ld;
    fmode_e fm;
    rdsel_e rd;
    skip_e  sk;

    logic [WORD_W-1:0] sta_q, sta_n, stb_q, stb_n;
    logic [WORD_W-1:0] da_q, da_n, ma_q, ma_n, wc_q, wc_n;
    logic [WORD_W-1:0] sta_view, stb_view, rd_val;
    logic sel_wlock, sel_seek_inc, sel_unsafe, sel_seeking, sel_not_ready;
    logic in_flight, eff_busy, load_ok, load_blk, launch_req;
    logic err_sum, attn_any;
    logic [SW_W-1:0]   sw_new;
    logic [UNIT_W-1:0] new_unit;
    logic [FUNC_W-1:0] new_func;

    dpk_iot_decode u_dec (
        .valid (iot_valid),
        .dev   (iot_dev),
        .pulse (iot_pulse),
        .ld    (ld),
        .fm    (fm),
        .rd    (rd),
        .sk    (sk)
    );

    dpk_unit_status #(.N(NUNITS), .UW(UNIT_W)) u_ust (
        .sel           (sta_q[A_UNIT_MSB -: UNIT_W]),
        .wlock         (unit_wlock),
        .attached      (unit_attached),
        .seeking       (unit_seeking),
        .cyl_bad       (unit_cyl_bad),
        .sel_wlock     (sel_wlock),
        .sel_seek_inc  (sel_seek_inc),
        .sel_unsafe    (sel_unsafe),
        .sel_seeking   (sel_seeking),
        .sel_not_ready (sel_not_ready)
    );

    dpk_launch_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .launch_req (launch_req),
        .unit_in    (new_unit),
        .func_in    (new_func),
        .busy_in    (busy),
        .go_strobe  (go_strobe),
        .go_unit    (go_unit),
        .go_func    (go_func),
        .in_flight  (in_flight)
    );

    assign eff_busy = busy | in_flight;
    assign load_ok  = (ld != LD_NONE) && !eff_busy;
    assign load_blk = (ld != LD_NONE) && eff_busy;

    // live views of the two status words
    always_comb begin
        attn_any = |stb_q[B_ATT0:B_ATT_LSB];
        err_sum  = (|sta_q[A_WLE:A_NOHDR]) | sel_seek_inc
                 | (|stb_q[B_UNSAFE:B_XERR_LSB]) | sel_unsafe;
        sta_view = sta_q;
        sta_view[A_SELWL] = sel_wlock;
        sta_view[A_SELSI] = sel_seek_inc;
        sta_view[A_ERR]   = err_sum;
        stb_view = stb_q;
        stb_view[B_UNSAFE]  = stb_q[B_UNSAFE] | sel_unsafe;
        stb_view[B_SEEKING] = sel_seeking;
        stb_view[B_NOTRDY]  = sel_not_ready;
        irq = ((sta_q[A_DONE] | err_sum) & sta_q[A_IE_DONE])
            | (attn_any & sta_q[A_IE_ATTN]);
    end

    always_comb begin
        unique case (rd)
            RD_STA:   rd_val = sta_view;
            RD_STB:   rd_val = stb_view;
            RD_DADDR: rd_val = da_q;
            RD_MADDR: rd_val = ma_q;
            RD_WCNT:  rd_val = wc_q;
            default:  rd_val = '0;
        endcase
        ac_out = ac_in | rd_val;
        unique case (sk)
            SK_ANY:    skip = sta_q[A_DONE] | err_sum | attn_any;
            SK_ATTN:   skip = attn_any;
            SK_DONE:   skip = sta_q[A_DONE];
            SK_ERR:    skip = err_sum;
            SK_ALWAYS: skip = 1'b1;
            default:   skip = 1'b0;
        endcase
    end

    // function field update
    always_comb begin
        unique case (fm)
            FM_CLEAR: sw_new = '0;
            FM_ANDZ:  sw_new = sta_q[WORD_W-1:A_SW_LSB] & ac_in[WORD_W-1:A_SW_LSB];
            FM_ORONE: sw_new = sta_q[WORD_W-1:A_SW_LSB] | ac_in[WORD_W-1:A_SW_LSB];
            default:  sw_new = ac_in[WORD_W-1:A_SW_LSB];
        endcase
        new_unit   = sw_new[SW_W-1 -: UNIT_W];
        new_func   = sw_new[SW_W-1-UNIT_W -: FUNC_W];
        launch_req = load_ok && (ld == LD_FUNC)
                   && sw_new[A_GO-A_SW_LSB] && !unit_seeking[new_unit];
    end

    // register next state
    always_comb begin
        sta_n = sta_q;
        stb_n = stb_q;
        da_n  = da_q;
        ma_n  = ma_q;
        wc_n  = wc_q;
        if (load_blk) stb_n[B_PGM] = 1'b1;
        if (load_ok) begin
            unique case (ld)
                LD_DADDR: begin
                    da_n = ac_in;
                    if (int'(ac_in[DA_SECT_LSB +: DA_SECT_W]) >= NSECT) sta_n[A_BADSECT] = 1'b1;
                    if (int'(ac_in[DA_SURF_LSB +: DA_SURF_W]) >= NSURF) sta_n[A_BADSURF] = 1'b1;
                    if (int'(ac_in[DA_CYL_LSB +: DA_CYL_W]) >= NCYL)    sta_n[A_BADCYL]  = 1'b1;
                end
                LD_CLRST: begin
                    sta_n[A_NOHDR] = 1'b0;
                    sta_n[A_DONE]  = 1'b0;
                    stb_n[B_PGM:B_XERR_LSB] = '0;
                end
                LD_MADDR: ma_n = ac_in;
                LD_WCNT:  wc_n = ac_in;
                LD_FUNC: begin
                    sta_n[WORD_W-1:A_SW_LSB] = sw_new;
                    sta_n[A_DONE] = 1'b0;
                    if (launch_req) begin
                        sta_n[A_NOHDR] = 1'b0;
                        stb_n[B_PGM:B_XERR_LSB] = '0;
                        stb_n[B_ATT0 - int'(new_unit)] = 1'b0;
                    end
                end
                default: ;
            endcase
        end
        sta_n = sta_n | (post_a & POST_A_MASK);
        stb_n = stb_n | (post_b & POST_B_MASK);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sta_q <= '0;
            stb_q <= '0;
            da_q  <= '0;
            ma_q  <= '0;
            wc_q  <= '0;
        end else begin
            sta_q <= sta_n;
            stb_q <= stb_n;
            da_q  <= da_n;
            ma_q  <= ma_n;
            wc_q  <= wc_n;
        end
    end

    p_blocked_load_keeps_da_r6: assert property (@(posedge clk) disable iff (!rst_n)
        load_blk |=> $stable(da_q));
    p_blocked_load_flags_pgm_r6: assert property (@(posedge clk) disable iff (!rst_n)
        load_blk |=> stb_q[B_PGM]);
    p_func_load_drops_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (load_ok && ld == LD_FUNC && !post_a[A_DONE]) |=> !sta_q[A_DONE]);
    p_clear_status_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (load_ok && ld == LD_CLRST && !post_a[A_NOHDR] && !post_b[B_PGM])
        |=> (!sta_q[A_NOHDR] && !stb_q[B_PGM]));
endmodule

// File: tb/dpk_ctrl_regs_tb.sv
module dpk_ctrl_regs_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        iot_valid = 1'b0;
    logic        iot_dev = 1'b0;
    logic [5:0]  iot_pulse = '0;
    logic [17:0] ac_in = '0;
    logic [17:0] ac_out;
    logic        skip;
    logic [7:0]  unit_wlock = 8'h20;
    logic [7:0]  unit_attached = 8'hFF;
    logic [7:0]  unit_seeking = 8'h00;
    logic [7:0]  unit_cyl_bad = 8'h00;
    logic        busy = 1'b0;
    logic        drop = 1'b0;
    logic [17:0] post_a = '0;
    logic [17:0] post_b = '0;
    logic        go_strobe;
    logic [2:0]  go_unit, go_func;
    logic        irq;

    int n_run = 0;
    int n_fail = 0;

    typedef struct {
        logic [17:0] exp_ac;
        logic        exp_sk;
        string       tag;
    } item_t;
    item_t sb_q[$];
    event mon_ev;

    always #(CLK_PERIOD/2) clk = ~clk;

    dpk_ctrl_regs u_dut (
        .clk(clk), .rst_n(rst_n), .iot_valid(iot_valid), .iot_dev(iot_dev),
        .iot_pulse(iot_pulse), .ac_in(ac_in), .ac_out(ac_out), .skip(skip),
        .unit_wlock(unit_wlock), .unit_attached(unit_attached),
        .unit_seeking(unit_seeking), .unit_cyl_bad(unit_cyl_bad),
        .busy(busy), .post_a(post_a), .post_b(post_b),
        .go_strobe(go_strobe), .go_unit(go_unit), .go_func(go_func), .irq(irq)
    );

    // engine model: busy rises the cycle after the strobe
    always @(posedge clk) begin
        if (go_strobe) busy <= 1'b1;
        else if (drop) busy <= 1'b0;
    end

    // scoreboard monitor
    always begin
        @(mon_ev);
        #1;
        if (sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            n_run++;
            if (ac_out !== it.exp_ac || skip !== it.exp_sk) begin
                n_fail++;
                $display("FAIL %s: ac_out=%o skip=%b expected ac_out=%o skip=%b",
                         it.tag, ac_out, skip, it.exp_ac, it.exp_sk);
            end
        end
    end

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0o expected=%0o", tag, act, exp);
        end
    endtask

    // kind: bit2 load, bit1 read, bit0 skip
    task automatic iot(input logic dev, input logic [1:0] sub, input logic [2:0] kind,
                       input logic [17:0] ac, input logic chk,
                       input logic [17:0] exp_ac, input logic exp_sk, input string tag);
        @(negedge clk);
        iot_valid = 1'b1; iot_dev = dev; iot_pulse = {sub, 1'b0, kind}; ac_in = ac;
        if (chk) begin
            item_t it;
            it.exp_ac = exp_ac; it.exp_sk = exp_sk; it.tag = tag;
            sb_q.push_back(it);
            ->mon_ev;
        end
        @(negedge clk);
        iot_valid = 1'b0; iot_pulse = '0; ac_in = '0;
    endtask

    task automatic rd(input logic dev, input logic [1:0] sub, input logic [17:0] exp, input string tag);
        iot(dev, sub, 3'b010, 18'o0, 1'b1, exp, 1'b0, tag);
    endtask

    task automatic ld(input logic dev, input logic [1:0] sub, input logic [17:0] ac);
        iot(dev, sub, 3'b100, ac, 1'b0, 18'o0, 1'b0, "");
    endtask

    task automatic sk(input logic dev, input logic [1:0] sub, input logic exp, input string tag);
        iot(dev, sub, 3'b001, 18'o0, 1'b1, 18'o0, exp, tag);
    endtask

    task automatic post(input logic [17:0] a, input logic [17:0] b);
        @(negedge clk);
        post_a = a; post_b = b;
        @(negedge clk);
        post_a = '0; post_b = '0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual=expired expected=done");
        finish_run();
    end

    initial begin
        do_reset();
        // R1 reset state
        rd(0, 0, 18'o000000, "R1 status A");
        rd(0, 1, 18'o000000, "R1 status B");
        rd(1, 1, 18'o000000, "R1 disk address");
        rd(1, 2, 18'o000000, "R1 memory address");
        rd(1, 3, 18'o000000, "R1 word count");
        check(irq, 0, "R1 irq");
        check(go_strobe, 0, "R1 go_strobe");

        // R4 / R3 address registers
        ld(0, 0, 18'o012142);
        iot(1, 1, 3'b010, 18'o400000, 1'b1, 18'o412142, 1'b0, "R3 DA OR into ac_in");
        ld(0, 2, 18'o000777);
        rd(1, 2, 18'o000777, "R3 memory address");
        ld(0, 3, 18'o777000);
        rd(1, 3, 18'o777000, "R3 word count");
        rd(1, 0, 18'o000000, "R3 device 1 subcode 0 reads zero");
        ld(0, 0, 18'o625151);
        rd(0, 0, 18'o000000, "R4 last valid sector/surface/cylinder");
        ld(0, 0, 18'o627212);
        rd(0, 0, 18'o000341, "R4 out of range fields, R8 error");
        do_reset();

        // R5 function loads, R9 write lock of unit 5
        ld(1, 3, 18'o524000);
        rd(0, 0, 18'o524010, "R5 full load, R9 write lock");
        ld(1, 1, 18'o773777);
        rd(0, 0, 18'o520010, "R5 AND-in zeros");
        ld(1, 2, 18'o002000);
        rd(0, 0, 18'o522010, "R5 OR-in ones");
        ld(1, 0, 18'o777777);
        rd(0, 0, 18'o000000, "R5 clear mode");

        // R12 posting, R2 skips, R5 done clear
        post(18'o000002, 18'o0);
        rd(0, 0, 18'o000002, "R12 posted done");
        sk(0, 2, 1'b1, "R2 skip on done");
        sk(0, 3, 1'b0, "R2 no skip on error");
        sk(0, 0, 1'b1, "R2 skip on any");
        sk(0, 1, 1'b0, "R2 no skip on attention");
        sk(1, 1, 1'b1, "R2 device 1 always skips");
        ld(1, 2, 18'o000000);
        rd(0, 0, 18'o000000, "R5 function load clears done");

        // R10 interrupt from done
        ld(1, 3, 18'o004000);
        check(irq, 0, "R10 irq low with enable only");
        post(18'o000002, 18'o0);
        check(irq, 1, "R10 irq from done");
        ld(0, 1, 18'o0);
        check(irq, 0, "R10 irq drops after clear status");
        rd(0, 0, 18'o004000, "R7 clear status drops done");

        // R10 interrupt from attention
        ld(1, 3, 18'o002000);
        post(18'o0, 18'o400000);
        check(irq, 1, "R10 irq from attention");
        sk(0, 1, 1'b1, "R2 skip on attention");
        rd(0, 1, 18'o400000, "R12 attention unit 0 at bit 17");
        do_reset();

        // R11 launch and R6 busy lockout
        post(18'o0, 18'o100000);
        rd(0, 1, 18'o100000, "R12 attention unit 2");
        ld(1, 3, 18'o211000);
        check(go_strobe, 1, "R11 strobe after go load");
        check(go_unit, 2, "R11 strobe unit");
        check(go_func, 1, "R11 strobe function");
        @(negedge clk);
        check(go_strobe, 0, "R11 strobe lasts one cycle");
        ld(0, 2, 18'o000777);
        rd(0, 1, 18'o000400, "R6 programming error, R11 attention cleared");
        rd(0, 0, 18'o211001, "R8 error from programming error");
        rd(1, 2, 18'o000000, "R6 blocked load left memory address");
        @(negedge clk); drop = 1'b1;
        @(negedge clk); drop = 1'b0;
        @(negedge clk);
        ld(0, 1, 18'o0);
        rd(0, 1, 18'o000000, "R7 clear status drops programming error");
        ld(1, 0, 18'o0);
        check(go_strobe, 0, "R11 clear mode does not launch");

        // R11 seeking unit blocks launch, R9 seeking status
        unit_seeking = 8'h08;
        ld(1, 3, 18'o301000);
        check(go_strobe, 0, "R11 no strobe for seeking unit");
        rd(0, 1, 18'o000003, "R9 seeking and not ready");
        rd(0, 0, 18'o301000, "R9 seeking is not an error");
        ld(1, 0, 18'o0);
        unit_seeking = 8'h00;

        // R9 unattached unit
        unit_attached = 8'hEF;
        ld(1, 3, 18'o400000);
        rd(0, 1, 18'o001001, "R9 unattached unsafe and not ready");
        rd(0, 0, 18'o400001, "R8 error from unsafe");
        ld(1, 0, 18'o0);
        unit_attached = 8'hFF;

        // R9 cylinder out of range
        unit_cyl_bad = 8'h01;
        @(negedge clk);
        rd(0, 0, 18'o000005, "R9 seek incomplete and R8 error");
        unit_cyl_bad = 8'h00;
        @(negedge clk);
        rd(0, 0, 18'o000000, "R9 seek incomplete follows live input");

        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule